// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is a synthesizable I2C target that makes a small on-chip byte array look like a serial EEPROM on a two-wire bus. It samples SCL and SDA with the system clock, finds START and STOP conditions, and answers only to a device address built from a fixed four-bit prefix and three strap inputs. A master writes by sending the device address with the direction bit clear, a two-byte word address (high byte first), then any number of data bytes. It reads by sending the device address with the direction bit set, either straight away (current-address read) or after loading the pointer with an aborted write (random read), and keeps acknowledging to stream further bytes.

Write data is collected in a page buffer and goes into the array only after the STOP that ends the write. A programming period of a set number of clock cycles follows. While it lasts, the block ignores the bus and acknowledges nothing. SDA is open-drain: the block only ever pulls the line low, through an output-enable.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The block acknowledges an address byte only when bits 7..4 equal 1010 and bits 3..1 equal `strapAddr[2:0]`. On any other address byte it leaves SDA released on the ninth clock and ignores the bus until the next START.
- R2: With bit 0 of the address byte at 0 (write), the block acknowledges the next two bytes as a word address, high byte first. Only the low ADDR_W bits of the 16-bit value load the pointer.
- R3: The block acknowledges each write data byte and places it in the page buffer at the pointer's low six bits, which then increment and wrap inside the 64-byte page. A later byte for the same offset replaces the earlier one.
- R4: The STOP that ends a write holding at least one data byte starts a programming period of PROG_CYCLES clocks. The array takes the buffered bytes only when that period ends, and it keeps the other bytes of the page.
- R5: During the programming period the block does not pull SDA low for any byte, including its own address.
- R6: With bit 0 of the address byte at 1 (read), the block sends the byte at the pointer MSB first and advances the full pointer after each byte. While the master acknowledges, it sends the next address, wrapping from the top of the array to 0.
- R7: When the master does not acknowledge a read byte, the block releases SDA and waits for STOP or START. The pointer stays one past the last byte sent, so a current-address read resumes from there.
- R8: A repeated START during a write discards the buffered data and starts no programming period, but keeps the loaded pointer.
- R9: `sdaOe` = 1 pulls SDA low. It changes only while the synchronized SCL is low, and it holds steady for the whole high phase of each SCL clock.
- R10: After reset `sdaOe` is 0, the pointer is 0, no programming period is running, and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| strapAddr | input | 3 | Board straps compared with address bits 3..1 |
| sdaOe | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |

## Verification
The hardest state to reach is a page that has wrapped: the write must start two bytes before the end of a page and run past 64 bytes, so the first two offsets get overwritten while the array still holds nothing new. The stimulus then reads the whole page back in one sequential burst that runs past the page edge. It also checks that a probe sent right after STOP goes unacknowledged, and that the same probe is acknowledged when a repeated START has aborted the write. A write at the last array address then exercises wrap within the page on the write side and wrap of the array on the read side.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WHI,
    ST_WLO,
    ST_WDATA,
    ST_RDATA,
    ST_WAIT
  } busState_e;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic loadHi;
    logic loadLo;
    logic storeByte;
    logic advanceRd;
    logic startProg;
    logic dropPage;
  } dpCmd_t;

endpackage

// File: rtl/i2c_eeprom_ctrl.sv
module i2c_eeprom_ctrl
  import i2c_eeprom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  input  logic       busy,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output logic       sdaOe,
  output dpCmd_t     cmd,
  output logic       sclSync,
  output logic       sdaSync,
  output logic       stopDet
);

  logic [1:0] sclPipe, sdaPipe;
  logic       sclPrev, sdaPrev;
  logic       sclRise, sclFall, startDet;

  busState_e  state, stateN;
  logic [3:0] bitCnt, bitCntN;
  logic       ackDrive, ackDriveN;
  logic       txOn, txOnN;
  logic       masterAck, masterAckN;
  logic       addrMatch;

  // two-stage synchronizers plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= 2'b11;
      sdaPipe <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[0], sclIn};
      sdaPipe <= {sdaPipe[0], sdaIn};
      sclPrev <= sclPipe[1];
      sdaPrev <= sdaPipe[1];
    end
  end

  assign sclSync  = sclPipe[1];
  assign sdaSync  = sdaPipe[1];
  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;

  assign addrMatch = (rxByte[7:4] == DEV_PREFIX) && (rxByte[3:1] == strapAddr);

  always_comb begin
    stateN     = state;
    bitCntN    = bitCnt;
    ackDriveN  = ackDrive;
    txOnN      = txOn;
    masterAckN = masterAck;
    cmd        = '0;
    if (busy) begin
      stateN    = ST_IDLE;
      bitCntN   = 4'd0;
      ackDriveN = 1'b0;
      txOnN     = 1'b0;
    end else if (stopDet) begin
      cmd.startProg = (state == ST_WDATA);
      stateN    = ST_IDLE;
      bitCntN   = 4'd0;
      ackDriveN = 1'b0;
      txOnN     = 1'b0;
    end else if (startDet) begin
      cmd.dropPage = 1'b1;
      stateN    = ST_DEV;
      bitCntN   = 4'd0;
      ackDriveN = 1'b0;
      txOnN     = 1'b0;
    end else if (state != ST_IDLE && state != ST_WAIT) begin
      if (sclRise) begin
        if (bitCnt < 4'd8 && state != ST_RDATA) cmd.shiftIn = 1'b1;
        if (bitCnt == 4'd8 && state == ST_RDATA) masterAckN = ~sdaSync;
        bitCntN = bitCnt + 4'd1;
      end else if (sclFall) begin
        if (state == ST_RDATA) begin
          if (bitCnt >= 4'd1 && bitCnt <= 4'd7) begin
            cmd.shiftOut = 1'b1;
          end else if (bitCnt == 4'd8) begin
            txOnN         = 1'b0;
            cmd.advanceRd = 1'b1;
          end else if (bitCnt == 4'd9) begin
            bitCntN = 4'd0;
            if (masterAck) begin
              cmd.loadTx = 1'b1;
              txOnN      = 1'b1;
            end else begin
              stateN = ST_WAIT;
            end
          end
        end else if (bitCnt == 4'd8) begin
          case (state)
            ST_DEV:   ackDriveN = addrMatch;
            ST_WHI:   begin ackDriveN = 1'b1; cmd.loadHi    = 1'b1; end
            ST_WLO:   begin ackDriveN = 1'b1; cmd.loadLo    = 1'b1; end
            ST_WDATA: begin ackDriveN = 1'b1; cmd.storeByte = 1'b1; end
            default:  ackDriveN = 1'b0;
          endcase
        end else if (bitCnt == 4'd9) begin
          ackDriveN = 1'b0;
          bitCntN   = 4'd0;
          case (state)
            ST_DEV: begin
              if (!ackDrive) begin
                stateN = ST_WAIT;
              end else if (rxByte[0]) begin
                stateN     = ST_RDATA;
                cmd.loadTx = 1'b1;
                txOnN      = 1'b1;
              end else begin
                stateN = ST_WHI;
              end
            end
            ST_WHI:  stateN = ST_WLO;
            ST_WLO:  stateN = ST_WDATA;
            default: stateN = state;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= 4'd0;
      ackDrive  <= 1'b0;
      txOn      <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateN;
      bitCnt    <= bitCntN;
      ackDrive  <= ackDriveN;
      txOn      <= txOnN;
      masterAck <= masterAckN;
    end
  end

  assign sdaOe = ackDrive | (txOn & ~txBit);

endmodule

// File: rtl/i2c_eeprom_dp.sv
module i2c_eeprom_dp
  import i2c_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 64,
  parameter int PROG_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic       sdaBit,
  output logic [7:0] rxByte,
  output logic       txBit,
  output logic       busy,
  output logic       progDone
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - PAGE_W;
  localparam int HI_W   = ADDR_W - 8;
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

  logic [7:0]            rxShift, txShift;
  logic [HI_W-1:0]       hiBits;
  logic [ADDR_W-1:0]     ptr;
  logic [7:0]            mem     [DEPTH];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [BASE_W-1:0]     progBase;
  logic [CNT_W-1:0]      progCnt;
  logic [PAGE_W-1:0]     pageOff;

  assign pageOff  = ptr[PAGE_W-1:0];
  assign rxByte   = rxShift;
  assign txBit    = txShift[7];
  assign busy     = (progCnt != '0);
  assign progDone = (progCnt == CNT_W'(1));

  // serial shift registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= 8'h00;
      txShift <= 8'hFF;
    end else begin
      if (cmd.shiftIn)  rxShift <= {rxShift[6:0], sdaBit};
      if (cmd.loadTx)        txShift <= mem[ptr];
      else if (cmd.shiftOut) txShift <= {txShift[6:0], 1'b1};
    end
  end

  // address pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiBits <= '0;
      ptr    <= '0;
    end else if (cmd.loadHi) begin
      hiBits <= rxShift[HI_W-1:0];
    end else if (cmd.loadLo) begin
      ptr <= {hiBits, rxShift};
    end else if (cmd.storeByte) begin
      ptr[PAGE_W-1:0] <= pageOff + PAGE_W'(1);
    end else if (cmd.advanceRd) begin
      ptr <= ptr + ADDR_W'(1);
    end
  end

  // page buffer and valid mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageValid <= '0;
    end else if (progDone || cmd.dropPage) begin
      pageValid <= '0;
    end else if (cmd.storeByte) begin
      pageValid[pageOff] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.storeByte) pageBuf[pageOff] <= rxShift;
  end

  // programming timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progCnt  <= '0;
      progBase <= '0;
    end else if (cmd.startProg && (pageValid != '0)) begin
      progCnt  <= CNT_W'(PROG_CYCLES);
      progBase <= ptr[ADDR_W-1:PAGE_W];
    end else if (busy) begin
      progCnt <= progCnt - CNT_W'(1);
    end
  end

  // storage array, written only when the programming period ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (progDone) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pageValid[i]) mem[{progBase, PAGE_W'(i)}] <= pageBuf[i];
      end
    end
  end

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 64,
  parameter int PROG_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  output logic       sdaOe
);

  dpCmd_t     cmd;
  logic [7:0] rxByte;
  logic       txBit, busy, progDone;
  logic       sclSync, sdaSync, stopDet;

  i2c_eeprom_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .strapAddr (strapAddr),
    .busy      (busy),
    .rxByte    (rxByte),
    .txBit     (txBit),
    .sdaOe     (sdaOe),
    .cmd       (cmd),
    .sclSync   (sclSync),
    .sdaSync   (sdaSync),
    .stopDet   (stopDet)
  );

  i2c_eeprom_dp #(
    .ADDR_W      (ADDR_W),
    .PAGE_BYTES  (PAGE_BYTES),
    .PROG_CYCLES (PROG_CYCLES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .sdaBit   (sdaSync),
    .rxByte   (rxByte),
    .txBit    (txBit),
    .busy     (busy),
    .progDone (progDone)
  );

endmodule

// File: rtl/i2c_eeprom_chk.sv
module i2c_eeprom_chk (
  input logic clk,
  input logic rstN,
  input logic sdaOe,
  input logic sclSync,
  input logic busy,
  input logic stopDet,
  input logic progDone
);

  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !$past(sclSync));

  assert_quiet_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

  assert_prog_after_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopDet));

  assert_commit_in_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    progDone |-> busy);

  assert_commit_ends_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    progDone |=> !busy);

endmodule

bind i2c_eeprom_slave i2c_eeprom_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .sdaOe    (sdaOe),
  .sclSync  (sclSync),
  .busy     (busy),
  .stopDet  (stopDet),
  .progDone (progDone)
);

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb_top;

  localparam int Q    = 4;
  localparam int PROG = 600;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclDrv = 1'b1;
  logic       sdaDrv = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sdaOe;
  wire        sdaLine = sdaDrv & ~sdaOe;

  int  nTests = 0;
  int  nFails = 0;
  bit  finished = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] monByte;
  event       gotByte;

  always #2 clk = ~clk;

  i2c_eeprom_slave #(.PROG_CYCLES(PROG)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclDrv),
    .sdaIn     (sdaLine),
    .strapAddr (strap),
    .sdaOe     (sdaOe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(gotByte) begin
    logic [7:0] e;
    string t;
    if (expQ.size() == 0) begin
      check(1'b0, "R6", "unexpected read byte", monByte, 0);
    end else begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(monByte == e, t, "read data", monByte, e);
    end
  end

  task automatic expectByte(input logic [7:0] v, input string t);
    expQ.push_back(v);
    tagQ.push_back(t);
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaDrv = 1'b1; ticks(Q);
    sclDrv = 1'b1; ticks(Q);
    sdaDrv = 1'b0; ticks(Q);
    sclDrv = 1'b0; ticks(Q);
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0; ticks(Q);
    sclDrv = 1'b1; ticks(Q);
    sdaDrv = 1'b1; ticks(Q);
  endtask

  task automatic writeBit(input bit b);
    sdaDrv = b; ticks(Q);
    sclDrv = 1'b1; ticks(2 * Q);
    sclDrv = 1'b0; ticks(Q);
  endtask

  task automatic readBit(output bit b, input bit chkStable);
    logic s0, s2;
    sdaDrv = 1'b1; ticks(Q);
    sclDrv = 1'b1; ticks(1);
    s0 = sdaLine; ticks(Q - 1);
    b  = sdaLine; ticks(Q - 1);
    s2 = sdaLine;
    if (chkStable) check(s0 == s2, "R9", "SDA moved while SCL high", s2, s0);
    ticks(1);
    sclDrv = 1'b0; ticks(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b, 1'b0);
    acked = !b;
  endtask

  task automatic recvByte(input bit mAck);
    bit b;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      readBit(b, 1'b1);
      v[i] = b;
    end
    monByte = v;
    -> gotByte;
    writeBit(!mAck);
  endtask

  task automatic readBurst(input int n);
    for (int i = 0; i < n; i++) recvByte(i != n - 1);
  endtask

  function automatic logic [7:0] dev(input bit rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic setPointer(input logic [15:0] wa, input string t);
    bit a;
    startCond();
    sendByte(dev(1'b0), a); check(a, t, "write address ack", a, 1);
    sendByte(wa[15:8], a);  check(a, "R2", "word address high ack", a, 1);
    sendByte(wa[7:0], a);   check(a, "R2", "word address low ack", a, 1);
  endtask

  task automatic startRead(input string t);
    bit a;
    startCond();
    sendByte(dev(1'b1), a); check(a, t, "read address ack", a, 1);
  endtask

  initial begin
    bit a;
    ticks(5);
    check(sdaOe == 1'b0, "R10", "sdaOe during reset", sdaOe, 0);
    rstN = 1'b1;
    ticks(5);
    check(sdaOe == 1'b0, "R10", "sdaOe after reset", sdaOe, 0);

    // R10: erased contents via random read
    setPointer(16'h0005, "R1");
    startRead("R1");
    expectByte(8'hFF, "R10");
    readBurst(1);
    stopCond();

    // R3/R4: short page write, then probe during programming
    setPointer(16'h0010, "R2");
    sendByte(8'hA5, a); check(a, "R3", "data ack", a, 1);
    sendByte(8'h3C, a); check(a, "R3", "data ack", a, 1);
    sendByte(8'h7E, a); check(a, "R3", "data ack", a, 1);
    stopCond();
    startCond();
    sendByte(dev(1'b0), a); check(!a, "R5", "address acked while programming", a, 0);
    stopCond();
    ticks(PROG + 100);

    // R4/R6: random read back, then R7 current-address read
    setPointer(16'h0010, "R4");
    startRead("R4");
    expectByte(8'hA5, "R4");
    readBurst(1);
    stopCond();
    startRead("R7");
    expectByte(8'h3C, "R7");
    readBurst(1);
    stopCond();

    // R1: wrong strap and wrong prefix are not acknowledged
    startCond();
    sendByte({4'b1010, 3'b100, 1'b0}, a); check(!a, "R1", "wrong strap acked", a, 0);
    stopCond();
    startCond();
    sendByte({4'b1011, strap, 1'b1}, a); check(!a, "R1", "wrong prefix acked", a, 0);
    check(sdaOe == 1'b0, "R1", "SDA held after mismatch", sdaOe, 0);
    stopCond();

    // R3: page write overflow, 66 bytes starting two before page end
    setPointer(16'h00BE, "R3");
    for (int i = 0; i < 66; i++) begin
      sendByte(8'(i + 1), a);
      if (i == 65) check(a, "R3", "66th data ack", a, 1);
    end
    stopCond();
    ticks(PROG + 100);
    setPointer(16'h0080, "R3");
    startRead("R3");
    for (int k = 0; k < 64; k++) begin
      if (k < 62) expectByte(8'(k + 3), "R3");
      else        expectByte(8'(k + 3), "R3");
    end
    expectByte(8'hFF, "R6");
    readBurst(65);
    stopCond();

    // R2/R3/R6: high address bits beyond the array ignored, wraps
    setPointer(16'h7FFF, "R2");
    sendByte(8'h5A, a); check(a, "R3", "data ack at top", a, 1);
    sendByte(8'hC3, a); check(a, "R3", "data ack after wrap", a, 1);
    stopCond();
    ticks(PROG + 100);
    setPointer(16'h01FF, "R6");
    startRead("R6");
    expectByte(8'h5A, "R6");
    expectByte(8'hFF, "R6");
    readBurst(2);
    stopCond();
    setPointer(16'h01C0, "R3");
    startRead("R3");
    expectByte(8'hC3, "R3");
    readBurst(1);
    stopCond();

    // R8: write aborted by repeated START programs nothing
    setPointer(16'h0020, "R8");
    sendByte(8'h11, a); check(a, "R8", "data ack", a, 1);
    startRead("R8");
    expectByte(8'hFF, "R8");
    readBurst(1);
    stopCond();
    setPointer(16'h0020, "R8");
    startRead("R8");
    expectByte(8'hFF, "R8");
    readBurst(1);
    stopCond();

    ticks(20);
    check(expQ.size() == 0, "R6", "scoreboard items left", expQ.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

endmodule